// File: doc/BRIEF.md
# Proportional-Integral Counter Loop Filter

This block is the loop filter of an all-digital phase-locked loop. It runs on the fast system clock and takes two phase-error pulses from a phase detector: one asks for a higher count and one for a lower count. It also takes the reference input. Both pulses drive two signed up/down counters. The proportional counter starts from zero in every reference period. The integral counter runs on without being cleared.

At each rising edge of the reference, the block scales both counts with arithmetic right shifts and adds them. The sum, clamped to a legal range, is latched as the divider value for a numerically controlled oscillator. The proportional counter is then cleared. A preset port lets an outside controller load both counters in one cycle, so that a large step in input frequency can be captured quickly.

Top module: `pi_count_filter`

## Requirements
- R1: Reset (active-low `rstN`) clears both counters to zero and sets `divOut` to 1.
- R2: When `incPulse` is high and `decPulse` is low, both counters increase by one on each `clk` rising edge.
- R3: When `decPulse` is high and `incPulse` is low, both counters decrease by one on each `clk` rising edge.
- R4: When both pulses are low, or both are high, the counters hold their values.
- R5: `fin` passes through a two-flop synchronizer and a rise detector. `divOut` updates on the third `clk` rising edge after a `fin` rise. A falling edge of `fin`, or a steady level, never updates it.
- R6: In the cycle that latches `divOut`, the proportional counter is cleared and the integral counter keeps its value.
- R7: With `presetEn` high, the proportional counter loads `presetProp` and the integral counter loads `presetInteg`. Preset takes priority over counting and over the clear.
- R8: Each counter saturates at its signed limits, +2047 and -2048 at the default width of 12, and never wraps.
- R9: The latched value is (proportional >>> PROP_SHIFT) + (integral >>> INTEG_SHIFT). The shifts are arithmetic, so they round toward minus infinity, and the defaults are 1 and 2. The value is clamped to the range 1 to 2^N_W-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fin | input | 1 | Reference input (asynchronous) |
| incPulse | input | 1 | Phase-error pulse requesting a count up |
| decPulse | input | 1 | Phase-error pulse requesting a count down |
| presetEn | input | 1 | Load both counters from the preset values |
| presetProp | input | CNT_W | Signed preset for the proportional counter |
| presetInteg | input | CNT_W | Signed preset for the integral counter |
| divOut | output | N_W | Latched divider value for the oscillator |

## Verification
On every cycle, the assertions check the single-step change of the integral counter under an up or down pulse. They also check that the counters hold when there is no request, that saturation stops at the limit, and that the proportional counter is cleared after a latch. Beyond these, they check that `divOut` only moves on a latch strobe and never falls below 1, and that the up and down strobes are never both active. Only the bench scenarios can show the end-to-end results. These are the exact shift-and-add values, the three-edge latency from `fin`, the refusal to latch on a falling or held reference, the clamp on a negative sum, and recovery from the lower saturation limit without wrap.

// File: rtl/pi_filter_pkg.sv
package pi_filter_pkg;
  typedef struct packed {
    logic countUp;
    logic countDown;
    logic latchN;
    logic preset;
  } filtStrobe_t;
endpackage

// File: rtl/pi_filter_ctrl.sv
module pi_filter_ctrl
  import pi_filter_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        fin,
  input  logic        incPulse,
  input  logic        decPulse,
  input  logic        presetEn,
  output filtStrobe_t strb
);
  logic finS1, finS2, finS3;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      finS1 <= 1'b0;
      finS2 <= 1'b0;
      finS3 <= 1'b0;
    end else begin
      finS1 <= fin;
      finS2 <= finS1;
      finS3 <= finS2;
    end
  end

  always_comb begin
    strb.countUp   = incPulse & ~decPulse;
    strb.countDown = decPulse & ~incPulse;
    strb.latchN    = finS2 & ~finS3;
    strb.preset    = presetEn;
  end

  // R4: opposing requests never both reach the datapath
  a_r4_no_dual_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.countUp, strb.countDown}));

  // R5: a latch strobe lasts exactly one cycle
  a_r5_single_latch: assert property (@(posedge clk) disable iff (!rstN)
    strb.latchN |=> !strb.latchN);
endmodule

// File: rtl/pi_filter_datapath.sv
module pi_filter_datapath
  import pi_filter_pkg::*;
#(
  parameter int CNT_W       = 12,
  parameter int N_W         = 12,
  parameter int PROP_SHIFT  = 1,
  parameter int INTEG_SHIFT = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  filtStrobe_t             strb,
  input  logic signed [CNT_W-1:0] presetProp,
  input  logic signed [CNT_W-1:0] presetInteg,
  output logic        [N_W-1:0]   divOut
);
  localparam int SUM_W = (CNT_W + 1 > N_W + 1) ? CNT_W + 1 : N_W + 1;
  localparam logic signed [CNT_W-1:0] C_MAX = {1'b0, {(CNT_W-1){1'b1}}};
  localparam logic signed [CNT_W-1:0] C_MIN = {1'b1, {(CNT_W-1){1'b0}}};
  localparam logic signed [SUM_W-1:0] N_MAX = $signed({{(SUM_W-N_W){1'b0}}, {N_W{1'b1}}});
  localparam logic signed [SUM_W-1:0] N_ONE = $signed({{(SUM_W-1){1'b0}}, 1'b1});

  logic signed [CNT_W-1:0] propCnt, integCnt;
  logic signed [CNT_W-1:0] propStep, integStep;
  logic signed [SUM_W-1:0] propWide, integWide, sumVal;
  logic        [N_W-1:0]   nNext;

  function automatic logic signed [CNT_W-1:0] satStep(
    input logic signed [CNT_W-1:0] v, input logic up, input logic dn);
    if (up && v != C_MAX)      return v + CNT_W'(1);
    else if (dn && v != C_MIN) return v - CNT_W'(1);
    else                       return v;
  endfunction

  always_comb begin
    propStep  = satStep(propCnt,  strb.countUp, strb.countDown);
    integStep = satStep(integCnt, strb.countUp, strb.countDown);
    propWide  = propCnt;
    integWide = integCnt;
    sumVal    = (propWide >>> PROP_SHIFT) + (integWide >>> INTEG_SHIFT);
    if (sumVal < N_ONE)      nNext = N_W'(1);
    else if (sumVal > N_MAX) nNext = N_MAX[N_W-1:0];
    else                     nNext = sumVal[N_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      propCnt  <= '0;
      integCnt <= '0;
      divOut   <= N_W'(1);
    end else begin
      if (strb.latchN) divOut <= nNext;
      if (strb.preset) begin
        propCnt  <= presetProp;
        integCnt <= presetInteg;
      end else begin
        propCnt  <= strb.latchN ? '0 : propStep;
        integCnt <= integStep;
      end
    end
  end

  // R2: single upward step of the integral counter
  a_r2_integ_up: assert property (@(posedge clk) disable iff (!rstN)
    (strb.countUp && !strb.preset && integCnt != C_MAX)
      |=> integCnt == $past(integCnt) + CNT_W'(1));

  // R3: single downward step of the integral counter
  a_r3_integ_down: assert property (@(posedge clk) disable iff (!rstN)
    (strb.countDown && !strb.preset && integCnt != C_MIN)
      |=> integCnt == $past(integCnt) - CNT_W'(1));

  // R4: no request means both counters hold
  a_r4_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.countUp && !strb.countDown && !strb.preset && !strb.latchN)
      |=> ($stable(propCnt) && $stable(integCnt)));

  // R6: proportional counter is cleared after a latch
  a_r6_prop_clear: assert property (@(posedge clk) disable iff (!rstN)
    (strb.latchN && !strb.preset) |=> propCnt == '0);

  // R8: saturation at the top limit
  a_r8_sat_top: assert property (@(posedge clk) disable iff (!rstN)
    (integCnt == C_MAX && strb.countUp && !strb.preset) |=> integCnt == C_MAX);

  // R8: saturation at the bottom limit
  a_r8_sat_bottom: assert property (@(posedge clk) disable iff (!rstN)
    (integCnt == C_MIN && strb.countDown && !strb.preset) |=> integCnt == C_MIN);

  // R5: divider value only moves on a latch strobe
  a_r5_div_stable: assert property (@(posedge clk) disable iff (!rstN)
    !strb.latchN |=> $stable(divOut));

  // R9: divider value never below one
  a_r9_min_one: assert property (@(posedge clk) disable iff (!rstN)
    divOut != '0);
endmodule

// File: rtl/pi_count_filter.sv
module pi_count_filter
  import pi_filter_pkg::*;
#(
  parameter int CNT_W       = 12,
  parameter int N_W         = 12,
  parameter int PROP_SHIFT  = 1,
  parameter int INTEG_SHIFT = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    fin,
  input  logic                    incPulse,
  input  logic                    decPulse,
  input  logic                    presetEn,
  input  logic signed [CNT_W-1:0] presetProp,
  input  logic signed [CNT_W-1:0] presetInteg,
  output logic        [N_W-1:0]   divOut
);
  filtStrobe_t strb;

  pi_filter_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .fin(fin), .incPulse(incPulse),
    .decPulse(decPulse), .presetEn(presetEn), .strb(strb)
  );

  pi_filter_datapath #(
    .CNT_W(CNT_W), .N_W(N_W), .PROP_SHIFT(PROP_SHIFT), .INTEG_SHIFT(INTEG_SHIFT)
  ) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .presetProp(presetProp),
    .presetInteg(presetInteg), .divOut(divOut)
  );
endmodule

// File: tb/tb_pi_count_filter.sv
module tb_pi_count_filter;
  localparam int CNT_W = 12;
  localparam int N_W   = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic fin = 1'b0, incPulse = 1'b0, decPulse = 1'b0, presetEn = 1'b0;
  logic signed [CNT_W-1:0] presetProp = '0, presetInteg = '0;
  logic [N_W-1:0] divOut;

  int nChecks = 0, nFails = 0, cycles = 0;
  bit done = 1'b0;

  pi_count_filter dut (.*);

  always #5 clk = ~clk;

  // columns: presetProp, presetInteg, upCycles, downCycles, expected divOut
  localparam int VEC [6][5] = '{
    '{   0,   0, 10, 0,   7 },
    '{   0, 400,  0, 0, 100 },
    '{ 100, 200,  4, 0, 103 },
    '{   0,  40,  0, 6,   5 },
    '{-100,  40,  0, 0,   1 },
    '{   3,   7,  0, 0,   2 }
  };

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic doPreset(input int p, input int i);
    @(negedge clk);
    presetEn = 1'b1; presetProp = CNT_W'(p); presetInteg = CNT_W'(i);
    @(negedge clk);
    presetEn = 1'b0;
  endtask

  task automatic drive(input logic up, input logic dn, input int n);
    @(negedge clk);
    incPulse = up; decPulse = dn;
    repeat (n) @(negedge clk);
    incPulse = 1'b0; decPulse = 1'b0;
  endtask

  task automatic pulseFin();
    @(negedge clk); fin = 1'b1;
    repeat (3) @(negedge clk);
    fin = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      nFails++;
      $display("FAIL watchdog: actual %0d expected below 100000 cycles", cycles);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset divOut", int'(divOut), 1);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R1: counters start at zero: 8 up steps give 4 + 2
    drive(1'b1, 1'b0, 8);
    pulseFin();
    check("R1 counters cleared by reset", int'(divOut), 6);

    // R2 R3 R4 R9: vector table
    for (int k = 0; k < 6; k++) begin
      doPreset(VEC[k][0], VEC[k][1]);
      if (VEC[k][2] > 0) drive(1'b1, 1'b0, VEC[k][2]);
      if (VEC[k][3] > 0) drive(1'b0, 1'b1, VEC[k][3]);
      pulseFin();
      check($sformatf("R9 R2 R3 vector %0d", k), int'(divOut), VEC[k][4]);
    end

    // R6: proportional cleared, integral kept
    doPreset(0, 0);
    drive(1'b1, 1'b0, 20);
    pulseFin();
    check("R6 first latch", int'(divOut), 15);
    pulseFin();
    check("R6 integral kept, proportional cleared", int'(divOut), 5);

    // R4: both pulses high hold the counters
    doPreset(0, 40);
    drive(1'b1, 1'b1, 10);
    pulseFin();
    check("R4 both pulses hold", int'(divOut), 10);

    // R5: latency and edge sensitivity
    doPreset(0, 8);
    @(negedge clk); fin = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    check("R5 not yet latched after two edges", int'(divOut), 10);
    @(posedge clk); #1;
    check("R5 latched on third edge", int'(divOut), 2);
    drive(1'b1, 1'b0, 10);
    repeat (4) @(negedge clk);
    check("R5 steady high no latch", int'(divOut), 2);
    fin = 1'b0;
    repeat (5) @(negedge clk);
    check("R5 falling edge no latch", int'(divOut), 2);
    pulseFin();
    check("R5 next rise latches", int'(divOut), 9);

    // R7: preset overrides counting in the same cycle
    @(negedge clk);
    incPulse = 1'b1; presetEn = 1'b1; presetProp = 12'sd20; presetInteg = 12'sd80;
    @(negedge clk);
    presetEn = 1'b0; incPulse = 1'b0;
    pulseFin();
    check("R7 preset wins over count", int'(divOut), 30);

    // R8: top saturation
    doPreset(2047, 2047);
    drive(1'b1, 1'b0, 5);
    pulseFin();
    check("R8 top saturation", int'(divOut), 1534);

    // R8 R9: bottom saturation then recovery without wrap
    doPreset(0, -2048);
    drive(1'b0, 1'b1, 3);
    pulseFin();
    check("R9 negative sum clamps to 1", int'(divOut), 1);
    drive(1'b1, 1'b0, 2060);
    pulseFin();
    check("R8 bottom saturation no wrap", int'(divOut), 1026);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule